// File: doc/BRIEF.md
# Strobe-Decoded SPI Port and Memory Bank Expander

This block sits between a small 8-bit processor and its static RAM. It gives the processor a latched 8-bit output port, four SPI channels and a banked upper memory window without any new processor pins. It does this by watching the existing read and write strobes. When both active-low strobes are low at the same time, the access cannot be a normal memory access. The block treats it as a port write. The data bus is not usable in that state, so the port value comes from the low eight address bits instead.

The port register holds the shared MOSI and SCLK lines, four active-low slave selects and a 2-bit bank number. The bank number chooses which 32K chunk of a 128K RAM appears when address bit 15 is high. Addresses below 32K always map to the lowest chunk. While SCLK is high, a plain read returns the four synchronized MISO lines on the low data bits in place of RAM data. Software runs the SPI protocol itself by toggling the port bits.

All outputs are registered. The RAM controls, the RAM address and the returned data follow the sampled strobes and address by one clock.

Top module: `spi_bank_expander`

## Requirements
- R1: While `rst` is high, the port outputs are held at their reset values: `spi_ss_n`=4'hF, `spi_sclk`=0, `spi_mosi`=0 and bank 0. Also `ram_we_n`=1, `ram_ce_n`=1 and `cpu_data_oe`=0.
- R2: A port cycle is a clock in which `cpu_oe_n` and `cpu_we_n` are both sampled low. The captured value reaches the port outputs on the first clock edge at which the overlap has ended, so it is not visible during the overlap. A cycle with only one strobe low never changes the port.
- R3: The latched port byte is the low eight address bits. Bit 0 drives `spi_mosi`, bit 1 drives `spi_sclk`, bit 2+i drives `spi_ss_n[i]` for i = 0 to 3, and bits 7:6 are the bank number.
- R4: `ram_we_n` is low, one clock after sampling, only for a cycle with `cpu_we_n` low and `cpu_oe_n` high. It stays high during port cycles.
- R5: `ram_oe_n` is low, one clock after sampling, only for a cycle with `cpu_oe_n` low, `cpu_we_n` high and `spi_sclk` low.
- R6: `ram_ce_n` is low, one clock after sampling, only when exactly one of the two strobes is low.
- R7: `ram_addr` is {2'b00, A14:A0} when A15 is 0 and {bank, A14:A0} when A15 is 1, registered one clock after the address is sampled.
- R8: `cpu_data_oe` is high, one clock after sampling, only for a plain read while `spi_sclk` is high. `cpu_data_out` then carries synchronized `spi_miso[i]` on bit i and zero on bits 7:4.
- R9: A change on `spi_miso` passes through two synchronizing flops. It first appears on `cpu_data_out` after the third rising clock edge following the change.
- R10: When the strobes overlap for several consecutive clocks, the address sampled in the last overlapped clock is the one latched.
- R11: A full byte exchanged by bit-banging the port with a selected loopback slave returns the slave's previous content, delivers the sent byte to that slave, and leaves unselected slaves unchanged. This holds on both the lowest and the highest port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address bus |
| cpu_oe_n | input | 1 | Processor read strobe, active low |
| cpu_we_n | input | 1 | Processor write strobe, active low |
| spi_miso | input | 4 | Serial input from each SPI channel |
| ram_addr | output | 17 | Physical RAM address after banking |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| spi_mosi | output | 1 | Shared serial output |
| spi_sclk | output | 1 | Shared serial clock |
| spi_ss_n | output | 4 | Per-channel slave select, active low |
| cpu_data_out | output | 8 | Data returned to the processor bus |
| cpu_data_oe | output | 1 | Drive enable for cpu_data_out |

## Verification
The hardest state to reach from the ports is a full serial byte exchange. It needs dozens of port cycles in a strict order, and the slave shifts only on clock edges that the block itself generates. The bench includes a loopback slave model that reacts to the block's SCLK and select outputs. It drives a software-style bit-bang loop through overlapped-strobe cycles only. Between raising SCLK and the read, it waits out the synchronizer delay. Multi-cycle overlaps and the exact synchronizer latency are set up with held strobes and a MISO change aligned to a clock.

// File: rtl/spix_pkg.sv
package spix_pkg;

  // Kind of processor bus cycle, derived from the two active-low strobes
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_PORT  = 2'd3
  } cyc_e;

  function automatic cyc_e cyc_decode(input logic oe_n, input logic we_n);
    case ({oe_n, we_n})
      2'b01:   return CYC_READ;
      2'b10:   return CYC_WRITE;
      2'b00:   return CYC_PORT;
      default: return CYC_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/spix_port_reg.sv
module spix_port_reg
  import spix_pkg::*;
#(
  parameter int SPI_PORTS = 4,
  parameter int BANK_W    = 2,
  parameter int LATCH_W   = 2 + SPI_PORTS + BANK_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cyc_e                 cyc,
  input  logic [LATCH_W-1:0]   addr_lo,
  output logic                 mosi,
  output logic                 sclk,
  output logic [SPI_PORTS-1:0] ss_n,
  output logic [BANK_W-1:0]    bank
);

  localparam logic [LATCH_W-1:0] RST_VAL = {{BANK_W{1'b0}}, {SPI_PORTS{1'b1}}, 2'b00};

  logic [LATCH_W-1:0] pend_q;
  logic [LATCH_W-1:0] port_q;
  logic               in_port_q;

  // Address is tracked during the overlap and committed when it ends
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= RST_VAL;
      port_q    <= RST_VAL;
      in_port_q <= 1'b0;
    end else begin
      in_port_q <= (cyc == CYC_PORT);
      if (cyc == CYC_PORT)
        pend_q <= addr_lo;
      if (in_port_q && cyc != CYC_PORT)
        port_q <= pend_q;
    end
  end

  assign mosi = port_q[0];
  assign sclk = port_q[1];
  assign ss_n = port_q[2 +: SPI_PORTS];
  assign bank = port_q[LATCH_W-1 -: BANK_W];

endmodule

// File: rtl/spix_sync.sv
module spix_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg_q[s] <= '0;
        else     stg_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg_q[s] <= '0;
        else     stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spix_bank_map.sv
module spix_bank_map #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 2,
  parameter int PHYS_W = ADDR_W - 1 + BANK_W
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BANK_W-1:0] bank,
  output logic [PHYS_W-1:0] phys_addr
);

  localparam int WIN_W = ADDR_W - 1;

  always_comb begin
    if (cpu_addr[ADDR_W-1])
      phys_addr = {bank, cpu_addr[WIN_W-1:0]};
    else
      phys_addr = {{BANK_W{1'b0}}, cpu_addr[WIN_W-1:0]};
  end

endmodule

// File: rtl/spi_bank_expander.sv
module spi_bank_expander
  import spix_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BANK_W      = 2,
  parameter int SPI_PORTS   = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          cpu_addr,
  input  logic                       cpu_oe_n,
  input  logic                       cpu_we_n,
  input  logic [SPI_PORTS-1:0]       spi_miso,
  output logic [ADDR_W+BANK_W-2:0]   ram_addr,
  output logic                       ram_ce_n,
  output logic                       ram_oe_n,
  output logic                       ram_we_n,
  output logic                       spi_mosi,
  output logic                       spi_sclk,
  output logic [SPI_PORTS-1:0]       spi_ss_n,
  output logic [DATA_W-1:0]          cpu_data_out,
  output logic                       cpu_data_oe
);

  localparam int PHYS_W  = ADDR_W - 1 + BANK_W;
  localparam int LATCH_W = 2 + SPI_PORTS + BANK_W;
  localparam int PAD_W   = DATA_W - SPI_PORTS;

  cyc_e                 cyc;
  logic [BANK_W-1:0]    bank_q;
  logic [SPI_PORTS-1:0] miso_s;
  logic [PHYS_W-1:0]    phys_addr;

  assign cyc = cyc_decode(cpu_oe_n, cpu_we_n);

  spix_port_reg #(
    .SPI_PORTS (SPI_PORTS),
    .BANK_W    (BANK_W),
    .LATCH_W   (LATCH_W)
  ) u_port (
    .clk     (clk),
    .rst     (rst),
    .cyc     (cyc),
    .addr_lo (cpu_addr[LATCH_W-1:0]),
    .mosi    (spi_mosi),
    .sclk    (spi_sclk),
    .ss_n    (spi_ss_n),
    .bank    (bank_q)
  );

  spix_sync #(
    .WIDTH  (SPI_PORTS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (spi_miso),
    .q   (miso_s)
  );

  spix_bank_map #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .PHYS_W (PHYS_W)
  ) u_map (
    .cpu_addr  (cpu_addr),
    .bank      (bank_q),
    .phys_addr (phys_addr)
  );

  // Registered RAM side and processor return path
  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr     <= '0;
      ram_ce_n     <= 1'b1;
      ram_oe_n     <= 1'b1;
      ram_we_n     <= 1'b1;
      cpu_data_out <= '0;
      cpu_data_oe  <= 1'b0;
    end else begin
      ram_addr     <= phys_addr;
      ram_ce_n     <= !(cyc == CYC_READ || cyc == CYC_WRITE);
      ram_we_n     <= (cyc != CYC_WRITE);
      ram_oe_n     <= !(cyc == CYC_READ && !spi_sclk);
      cpu_data_oe  <= (cyc == CYC_READ) && spi_sclk;
      cpu_data_out <= {{PAD_W{1'b0}}, miso_s};
    end
  end

endmodule

// File: rtl/spi_bank_expander_chk.sv
module spi_bank_expander_chk #(
  parameter int ADDR_W    = 16,
  parameter int BANK_W    = 2,
  parameter int SPI_PORTS = 4,
  parameter int DATA_W    = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic [ADDR_W-1:0]        cpu_addr,
  input logic                     cpu_oe_n,
  input logic                     cpu_we_n,
  input logic [ADDR_W+BANK_W-2:0] ram_addr,
  input logic                     ram_ce_n,
  input logic                     ram_oe_n,
  input logic                     ram_we_n,
  input logic                     spi_mosi,
  input logic                     spi_sclk,
  input logic [SPI_PORTS-1:0]     spi_ss_n,
  input logic [DATA_W-1:0]        cpu_data_out,
  input logic                     cpu_data_oe,
  input logic [BANK_W-1:0]        bank
);

  localparam int WIN_W = ADDR_W - 1;

  // R4
  ram_write_only_plain_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> $past(!cpu_we_n && cpu_oe_n));

  // R5
  ram_read_only_idle_spi_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_oe_n |-> $past(!cpu_oe_n && cpu_we_n && !spi_sclk));

  // R6
  ram_select_single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_ce_n |-> $past(cpu_oe_n != cpu_we_n));

  // R8
  single_bus_driver_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_data_oe |-> (ram_oe_n && cpu_data_out[DATA_W-1:SPI_PORTS] == '0));

  // R2
  port_changes_after_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable({bank, spi_ss_n, spi_sclk, spi_mosi}) |->
      ($past(!cpu_oe_n && !cpu_we_n, 2) && !$past(!cpu_oe_n && !cpu_we_n)));

  // R7
  window_offset_chk: assert property (@(posedge clk) disable iff (rst)
    ram_addr[WIN_W-1:0] == $past(cpu_addr[WIN_W-1:0]));

  // R7
  bank_select_chk: assert property (@(posedge clk) disable iff (rst)
    ram_addr[WIN_W +: BANK_W] ==
      ($past(cpu_addr[ADDR_W-1]) ? $past(bank) : {BANK_W{1'b0}}));

endmodule

bind spi_bank_expander spi_bank_expander_chk #(
  .ADDR_W    (ADDR_W),
  .BANK_W    (BANK_W),
  .SPI_PORTS (SPI_PORTS),
  .DATA_W    (DATA_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_addr     (cpu_addr),
  .cpu_oe_n     (cpu_oe_n),
  .cpu_we_n     (cpu_we_n),
  .ram_addr     (ram_addr),
  .ram_ce_n     (ram_ce_n),
  .ram_oe_n     (ram_oe_n),
  .ram_we_n     (ram_we_n),
  .spi_mosi     (spi_mosi),
  .spi_sclk     (spi_sclk),
  .spi_ss_n     (spi_ss_n),
  .cpu_data_out (cpu_data_out),
  .cpu_data_oe  (cpu_data_oe),
  .bank         (bank_q)
);

// File: tb/spi_bank_expander_test.sv
module spi_bank_expander_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_oe_n = 1'b1;
  logic        cpu_we_n = 1'b1;
  logic [3:0]  spi_miso;
  logic [16:0] ram_addr;
  logic        ram_ce_n, ram_oe_n, ram_we_n;
  logic        spi_mosi, spi_sclk;
  logic [3:0]  spi_ss_n;
  logic [7:0]  cpu_data_out;
  logic        cpu_data_oe;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  // Loopback slave models, updated away from the active edge
  logic       miso_force = 1'b0;
  logic [3:0] miso_val   = 4'h0;
  logic       slv_load   = 1'b1;
  logic [7:0] slv_init [4];
  logic [7:0] slv_sh   [4];
  logic [3:0] slv_smp;
  logic       prev_sclk;
  logic [3:0] slv_miso;

  always #2 clk = ~clk;

  spi_bank_expander uut (
    .clk          (clk),
    .rst          (rst),
    .cpu_addr     (cpu_addr),
    .cpu_oe_n     (cpu_oe_n),
    .cpu_we_n     (cpu_we_n),
    .spi_miso     (spi_miso),
    .ram_addr     (ram_addr),
    .ram_ce_n     (ram_ce_n),
    .ram_oe_n     (ram_oe_n),
    .ram_we_n     (ram_we_n),
    .spi_mosi     (spi_mosi),
    .spi_sclk     (spi_sclk),
    .spi_ss_n     (spi_ss_n),
    .cpu_data_out (cpu_data_out),
    .cpu_data_oe  (cpu_data_oe)
  );

  always @(negedge clk) begin
    prev_sclk <= spi_sclk;
    for (int i = 0; i < 4; i++) begin
      if (slv_load) begin
        slv_sh[i]  <= slv_init[i];
        slv_smp[i] <= 1'b0;
      end else if (!spi_ss_n[i]) begin
        if (spi_sclk && !prev_sclk) slv_smp[i] <= spi_mosi;
        if (!spi_sclk && prev_sclk) slv_sh[i]  <= {slv_sh[i][6:0], slv_smp[i]};
      end
    end
  end

  always_comb begin
    for (int i = 0; i < 4; i++) slv_miso[i] = !spi_ss_n[i] && slv_sh[i][7];
  end

  assign spi_miso = miso_force ? miso_val : slv_miso;

  // {addr, oe_n, we_n, exp ram_addr, exp we_n, exp oe_n, exp ce_n}, bank 0, SCLK low
  localparam logic [37:0] VEC [6] = '{
    {16'h1234, 1'b0, 1'b1, 17'h01234, 1'b1, 1'b0, 1'b0},
    {16'h7FFF, 1'b1, 1'b0, 17'h07FFF, 1'b0, 1'b1, 1'b0},
    {16'h8000, 1'b0, 1'b1, 17'h00000, 1'b1, 1'b0, 1'b0},
    {16'hFFFF, 1'b1, 1'b1, 17'h07FFF, 1'b1, 1'b1, 1'b1},
    {16'hC001, 1'b1, 1'b0, 17'h04001, 1'b0, 1'b1, 1'b0},
    {16'h00A5, 1'b1, 1'b1, 17'h000A5, 1'b1, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs are applied at a falling edge; outputs are looked at on the next one
  task automatic drive(input logic [15:0] a, input logic oe_n, input logic we_n);
    cpu_addr = a;
    cpu_oe_n = oe_n;
    cpu_we_n = we_n;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(16'h0000, 1'b1, 1'b1);
  endtask

  function automatic logic [7:0] pv(input logic [1:0] bank, input logic [3:0] ssn,
                                    input logic sclk, input logic mosi);
    return {bank, ssn, sclk, mosi};
  endfunction

  task automatic port_wr(input logic [7:0] v);
    drive({8'hA5, v}, 1'b0, 1'b0);
    idle();
  endtask

  task automatic exchange(input int p, input logic [7:0] tx, output logic [7:0] rx);
    logic [3:0] sel;
    sel = 4'hF;
    sel[p] = 1'b0;
    rx = 8'h00;
    for (int k = 7; k >= 0; k--) begin
      port_wr(pv(2'b00, sel, 1'b0, tx[k]));
      port_wr(pv(2'b00, sel, 1'b1, tx[k]));
      repeat (3) idle();
      drive(16'h0000, 1'b0, 1'b1);
      rx = {rx[6:0], cpu_data_out[p]};
      idle();
    end
    port_wr(pv(2'b00, sel, 1'b0, 1'b0));
    port_wr(pv(2'b00, 4'hF, 1'b0, 1'b0));
    repeat (2) idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    slv_init[0] = 8'h96;
    slv_init[1] = 8'h3B;
    slv_init[2] = 8'hE4;
    slv_init[3] = 8'h7E;

    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 ss_n", {28'd0, spi_ss_n}, 32'hF);
    check("R1 sclk", {31'd0, spi_sclk}, 32'h0);
    check("R1 mosi", {31'd0, spi_mosi}, 32'h0);
    check("R1 ram_we_n", {31'd0, ram_we_n}, 32'h1);
    check("R1 ram_ce_n", {31'd0, ram_ce_n}, 32'h1);
    check("R1 data_oe", {31'd0, cpu_data_oe}, 32'h0);
    rst = 1'b0;
    slv_load = 1'b0;
    idle();

    // Table walk: R4 R5 R6 R7 at bank 0
    for (int v = 0; v < 6; v++) begin
      drive(VEC[v][37:22], VEC[v][21], VEC[v][20]);
      check("R7 ram_addr", {15'd0, ram_addr}, {15'd0, VEC[v][19:3]});
      check("R4 ram_we_n", {31'd0, ram_we_n}, {31'd0, VEC[v][2]});
      check("R5 ram_oe_n", {31'd0, ram_oe_n}, {31'd0, VEC[v][1]});
      check("R6 ram_ce_n", {31'd0, ram_ce_n}, {31'd0, VEC[v][0]});
    end
    idle();

    // R7 every bank on the upper window, lower window fixed
    for (int b = 1; b < 4; b++) begin
      port_wr(pv(b[1:0], 4'hF, 1'b0, 1'b0));
      drive(16'h8123, 1'b0, 1'b1);
      check("R7 upper window", {15'd0, ram_addr}, {15'd0, b[1:0], 15'h0123});
      drive(16'h0123, 1'b0, 1'b1);
      check("R7 lower window", {15'd0, ram_addr}, 32'h00123);
      idle();
    end

    // R2 R3 R4 R6 port cycle
    drive(16'h55F9, 1'b0, 1'b0);
    check("R4 port cycle we_n", {31'd0, ram_we_n}, 32'h1);
    check("R6 port cycle ce_n", {31'd0, ram_ce_n}, 32'h1);
    check("R2 not yet visible", {28'd0, spi_ss_n}, 32'hF);
    idle();
    check("R3 ss_n", {28'd0, spi_ss_n}, 32'hE);
    check("R3 mosi", {31'd0, spi_mosi}, 32'h1);
    check("R3 sclk", {31'd0, spi_sclk}, 32'h0);
    drive(16'h8010, 1'b0, 1'b1);
    check("R3 bank field", {15'd0, ram_addr}, 32'h18010);
    idle();

    // R10 held overlap keeps the last address
    drive(16'h0001, 1'b0, 1'b0);
    drive(16'h003E, 1'b0, 1'b0);
    idle();
    check("R10 sclk", {31'd0, spi_sclk}, 32'h1);
    check("R10 mosi", {31'd0, spi_mosi}, 32'h0);

    // R2 single strobes leave the port alone
    drive(16'h0000, 1'b1, 1'b0);
    drive(16'h0000, 1'b0, 1'b1);
    idle();
    check("R2 single strobe sclk", {31'd0, spi_sclk}, 32'h1);
    check("R2 single strobe ss_n", {28'd0, spi_ss_n}, 32'hF);

    // R8 R5 return path with SCLK high
    miso_force = 1'b1;
    miso_val   = 4'hA;
    repeat (4) idle();
    drive(16'h0000, 1'b0, 1'b1);
    check("R8 data_oe", {31'd0, cpu_data_oe}, 32'h1);
    check("R8 data_out", {24'd0, cpu_data_out}, 32'h0A);
    check("R5 ram_oe_n while driving", {31'd0, ram_oe_n}, 32'h1);
    idle();

    // R9 synchronizer latency
    miso_val = 4'h5;
    repeat (4) idle();
    miso_val = 4'hA;
    drive(16'h0000, 1'b0, 1'b1);
    check("R9 edge1", {24'd0, cpu_data_out}, 32'h05);
    drive(16'h0000, 1'b0, 1'b1);
    check("R9 edge2", {24'd0, cpu_data_out}, 32'h05);
    drive(16'h0000, 1'b0, 1'b1);
    check("R9 edge3", {24'd0, cpu_data_out}, 32'h0A);
    idle();

    // R5 R8 SCLK low gives the bus back to RAM
    port_wr(8'h3C);
    drive(16'h0000, 1'b0, 1'b1);
    check("R8 no drive sclk low", {31'd0, cpu_data_oe}, 32'h0);
    check("R5 ram_oe_n sclk low", {31'd0, ram_oe_n}, 32'h0);
    idle();
    miso_force = 1'b0;

    // R11 loopback exchanges on the lowest and highest port
    exchange(0, 8'hC3, rx);
    check("R11 port0 rx", {24'd0, rx}, 32'h96);
    check("R11 port0 slave", {24'd0, slv_sh[0]}, 32'hC3);
    check("R11 port1 untouched", {24'd0, slv_sh[1]}, 32'h3B);
    exchange(3, 8'h21, rx);
    check("R11 port3 rx", {24'd0, rx}, 32'h7E);
    check("R11 port3 slave", {24'd0, slv_sh[3]}, 32'h21);
    check("R11 port2 untouched", {24'd0, slv_sh[2]}, 32'hE4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule